// File: doc/BRIEF.md
# Serial Port Strobe Generator

This block runs on a 2.4 MHz reference clock and derives the timing a DSP-facing synchronous serial port needs. It produces a receive bit qualifier, a transmit bit clock, and several periodic one-cycle strobes: a receive frame strobe that marks each new I/Q packet, a transmit frame strobe, and a speaker-sample strobe. It generates no data and converts nothing; shift registers and converters elsewhere in the chip use these signals to pace their transfers.

Every rate comes from one reference. The receive bit qualifier runs at the reference rate. The transmit bit clock is the reference divided by 2, giving 1.2 MHz. The transmit frame strobe comes every 50 cycles (48 kHz) and the receive frame strobe every 120 cycles (20 kHz). The speaker strobe comes every 300 cycles (8 kHz), but only while the host holds its enable high. Each strobe has its own counter. The transmit frame strobe is placed so that it always lands on a rising transmit clock edge.

Top module: `ssi_strobe_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge of `clk`, every output is low after that edge and all counters restart.
- R2: `rx_bit_en` is high after every edge at which `rst_n` is sampled high.
- R3: `tx_bclk` is low after reset and toggles on every running edge. It is high after odd-numbered running edges, where the first edge with `rst_n` high counts as edge 1.
- R4: `tx_frame_irq` is a one-cycle pulse after running edges 49, 99, 149, …, which gives a period of 50 cycles.
- R5: Every `tx_frame_irq` pulse coincides with a cycle in which `tx_bclk` has just risen from low to high.
- R6: `rx_frame_irq` is a one-cycle pulse after running edges 120, 240, …, which gives a period of 120 cycles.
- R7: While `spk_irq_en` stays high, `spk_irq` is a one-cycle pulse every 300 cycles.
- R8: While `spk_irq_en` is sampled low, `spk_irq` stays low after that edge.
- R9: Raising `spk_irq_en` restarts the speaker count. The first edge that samples it high counts as 1, and the first pulse follows enabled edge 300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.4 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spk_irq_en | input | 1 | Host enable for the speaker-sample strobe |
| rx_bit_en | output | 1 | Receive bit qualifier, high every running reference cycle |
| tx_bclk | output | 1 | Transmit bit clock, reference divided by 2 |
| tx_frame_irq | output | 1 | Transmit frame strobe, one cycle every 50 |
| rx_frame_irq | output | 1 | Receive frame strobe, one cycle every 120 |
| spk_irq | output | 1 | Speaker-sample strobe, one cycle every 300 while enabled |

## Verification
Some behaviour is checked by assertions on every cycle:
- every output is cleared by reset;
- `rx_bit_en` stays high while running;
- `tx_bclk` toggles on every running edge;
- every strobe is exactly one cycle wide;
- the transmit frame strobe always falls on a fresh rising edge of `tx_bclk`;
- the speaker strobe stays silent while disabled.

Other behaviour only the bench's scenarios can show. These are the absolute positions and periods of each strobe, the restart of the speaker count after the enable is dropped mid-period and raised again, and the recovery of every phase after a reset in the middle of a run. For these, a behavioural model counts edges since reset and since enable.

// File: rtl/ssi_strobe_pkg.sv
// Shared constants and types for the serial port strobe generator.
// Assumes a single reference clock domain; all ratios are in reference cycles.
package ssi_strobe_pkg;

    // Default division ratios from the reference clock
    localparam int unsigned TX_FRAME_DIV_DEF = 50;
    localparam int unsigned RX_FRAME_DIV_DEF = 120;
    localparam int unsigned SPK_DIV_DEF      = 300;

    // Bundle of all timing outputs produced by the block
    typedef struct packed {
        logic rx_bit;
        logic tx_bclk;
        logic tx_frame;
        logic rx_frame;
        logic spk;
    } strobe_bus_t;

endpackage

// File: rtl/ssi_rate_divider.sv
// Generic modulo counter that emits a registered one-cycle pulse on the
// DIV-th counted edge after restart. While run is low the count is held at
// INIT and the pulse is suppressed. Assumes DIV >= 2 and INIT < DIV.
module ssi_rate_divider #(
    parameter int unsigned DIV  = 50,
    parameter int unsigned INIT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
    localparam logic [CW-1:0] START = CW'(INIT);

    logic [CW-1:0] cnt;

    // Count running edges, wrap at DIV and raise the pulse on the wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= START;
            pulse <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            pulse <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            pulse <= 1'b0;
        end
    end

    // R4 R6 R7
    pulse_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R8
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pulse);

endmodule

// File: rtl/ssi_tx_clock.sv
// Transmit-side timing: a divide-by-2 bit clock plus a frame strobe placed
// on a rising bit clock edge. Assumes FRAME_DIV is even so that the
// alignment holds on every period, not only the first.
module ssi_tx_clock #(
    parameter int unsigned FRAME_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic frame
);
    // The clock is high after odd edges; starting the frame count one
    // step ahead puts its pulses on odd edges too.
    localparam int unsigned FRAME_INIT = 1;

    initial begin
        frame_div_even_chk: assert ((FRAME_DIV % 2) == 0 && FRAME_DIV >= 2);
    end

    // Toggle the bit clock on every running reference edge
    always_ff @(posedge clk) begin
        if (!rst_n) bclk <= 1'b0;
        else        bclk <= ~bclk;
    end

    ssi_rate_divider #(.DIV(FRAME_DIV), .INIT(FRAME_INIT)) u_frame_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (1'b1),
        .pulse (frame)
    );

    // R3
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bclk != $past(bclk)));

    // R5
    frame_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame |-> (bclk && !$past(bclk)));

endmodule

// File: rtl/ssi_strobe_gen.sv
// Top of the serial port strobe generator. From the reference clock it
// produces the receive bit qualifier, the transmit bit clock, the transmit
// and receive frame strobes, and a host-gated speaker-sample strobe.
// Assumes clk is the reference and rst_n is synchronous, active low.
module ssi_strobe_gen
    import ssi_strobe_pkg::*;
#(
    parameter int unsigned TX_FRAME_DIV = TX_FRAME_DIV_DEF,
    parameter int unsigned RX_FRAME_DIV = RX_FRAME_DIV_DEF,
    parameter int unsigned SPK_DIV      = SPK_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spk_irq_en,
    output logic rx_bit_en,
    output logic tx_bclk,
    output logic tx_frame_irq,
    output logic rx_frame_irq,
    output logic spk_irq
);
    strobe_bus_t sb;

    // Receive bit qualifier: high on every reference cycle once running
    always_ff @(posedge clk) begin
        if (!rst_n) sb.rx_bit <= 1'b0;
        else        sb.rx_bit <= 1'b1;
    end

    ssi_tx_clock #(.FRAME_DIV(TX_FRAME_DIV)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (sb.tx_bclk),
        .frame (sb.tx_frame)
    );

    ssi_rate_divider #(.DIV(RX_FRAME_DIV), .INIT(0)) u_rx_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (1'b1),
        .pulse (sb.rx_frame)
    );

    // The enable doubles as a restart: while low the count is held clear
    ssi_rate_divider #(.DIV(SPK_DIV), .INIT(0)) u_spk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (spk_irq_en),
        .pulse (sb.spk)
    );

    // Drive the ports from the bundle
    always_comb begin
        rx_bit_en    = sb.rx_bit;
        tx_bclk      = sb.tx_bclk;
        tx_frame_irq = sb.tx_frame;
        rx_frame_irq = sb.rx_frame;
        spk_irq      = sb.spk;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(rx_bit_en | tx_bclk | tx_frame_irq | rx_frame_irq | spk_irq));

    // R2
    rx_bit_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rx_bit_en);

    // R8
    spk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_irq_en |=> !spk_irq);

endmodule

// File: tb/ssi_strobe_gen_bench.sv
// Cycle-by-cycle behavioural reference for ssi_strobe_gen: counts running
// edges and enabled edges and derives every expected output from those counts.
module ssi_strobe_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spk_irq_en = 1'b0;
    logic rx_bit_en, tx_bclk, tx_frame_irq, rx_frame_irq, spk_irq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int n = 0;   // running edges since reset release
    int s = 0;   // consecutive enabled running edges
    bit done = 1'b0;

    always #4 clk = ~clk;

    ssi_strobe_gen u_ssi_strobe_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .spk_irq_en   (spk_irq_en),
        .rx_bit_en    (rx_bit_en),
        .tx_bclk      (tx_bclk),
        .tx_frame_irq (tx_frame_irq),
        .rx_frame_irq (rx_frame_irq),
        .spk_irq      (spk_irq)
    );

    // Reference model state update at each edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            n <= 0;
            s <= 0;
        end else begin
            n <= n + 1;
            s <= spk_irq_en ? s + 1 : 0;
        end
    end

    task automatic check(input string req, input string name, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at n=%0d s=%0d: actual %b expected %b", req, name, n, s, act, exp);
        end
    endtask

    // Compare every output on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            logic e_rx, e_tx, e_txf, e_rxf, e_spk;
            string rs;
            e_rx  = (n > 0);
            e_tx  = (n % 2) == 1;
            e_txf = (n > 0) && ((n + 1) % 50 == 0);
            e_rxf = (n > 0) && (n % 120 == 0);
            e_spk = (s > 0) && (s % 300 == 0);
            if (n == 0) begin
                // R1: all outputs low after a reset edge
                check("R1", "rx_bit_en", rx_bit_en, 1'b0);
                check("R1", "tx_bclk", tx_bclk, 1'b0);
                check("R1", "tx_frame_irq", tx_frame_irq, 1'b0);
                check("R1", "rx_frame_irq", rx_frame_irq, 1'b0);
                check("R1", "spk_irq", spk_irq, 1'b0);
            end else begin
                check("R2", "rx_bit_en", rx_bit_en, e_rx);
                check("R3", "tx_bclk", tx_bclk, e_tx);
                // R4 period; R5 alignment follows from matching both tx outputs
                check("R4", "tx_frame_irq", tx_frame_irq, e_txf);
                if (e_txf) check("R5", "tx_bclk_at_frame", tx_bclk, 1'b1);
                check("R6", "rx_frame_irq", rx_frame_irq, e_rxf);
                rs = (s == 0) ? "R8" : ((s <= 300) ? "R9" : "R7");
                check(rs, "spk_irq", spk_irq, e_spk);
            end
        end
    end

    task automatic run_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Stimulus: reset, disabled speaker, enable, mid-period disable, re-enable, mid-run reset
    initial begin
        run_cycles(4);
        rst_n = 1'b1;
        run_cycles(650);        // R8: speaker silent while disabled
        spk_irq_en = 1'b1;
        run_cycles(1000);       // R9 first pulse, R7 periodic
        spk_irq_en = 1'b0;
        run_cycles(150);
        spk_irq_en = 1'b1;      // R9 restart mid-period
        run_cycles(710);
        rst_n = 1'b0;           // R1 mid-run reset
        run_cycles(3);
        rst_n = 1'b1;
        run_cycles(400);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule